// File: doc/BRIEF.md
# Token-Chained Readout Bus Controller

This block moves one acquisition module's channel samples onto a shared, synchronous 32-bit readout bus. Several modules share the bus, and they are linked in a daisy chain by an active-low token. A module may drive the bus only while its incoming token is low. When its transfer is done, it pulls its own outgoing token low so that the next module in the chain can start.

One module in the chain is the master, chosen by a static configuration pin such as a slot identifier. The master opens its transfer with a header word taken from a status register and then sends its samples. All other modules send their samples only. The 16-bit channel samples travel in pairs, two per bus word. With the default sixteen channels, a transfer is eight data words, plus the header word when the module is master.

The bus side is a valid/ready stream:
- A word moves on a rising edge where both `bus_valid_o` and `bus_rdy_i` are high.
- While `bus_rdy_i` is low, the current word and `bus_valid_o` hold.
- `bus_valid_o` never depends on `bus_rdy_i`, so the sink may stall for any number of cycles.

If the token arrives before the samples are marked ready, the module sends nothing and passes the token on at once.

Top module: `tok_chain_readout`

## Requirements
- R1: `bus_valid_o` is high only while `tok_in_n` is low (the token is active low).
- R2: When `master_i` is high at the grant edge, the first word of the transfer equals the `hdr_i` value seen at that edge. The samples follow, so the transfer is NUM_CH/2+1 words.
- R3: When `master_i` is low at the grant edge, the transfer has no header. It is exactly NUM_CH/2 words, and the first word is the channel 0/1 pair.
- R4: Data word k carries channel 2k in bits 15:0 and channel 2k+1 in bits 31:16. Channel c enters on `samples_i[16c +: 16]`.
- R5: `tok_out_n` goes low in the cycle after the edge that accepts the last word. It stays low while `tok_in_n` stays low, and returns high in the cycle after an edge that sees `tok_in_n` high.
- R6: If `tok_in_n` is low and `data_rdy_i` is low at an idle edge, no word is sent and `tok_out_n` is low in the next cycle.
- R7: `bus_data_o` is all zeros whenever `bus_valid_o` is low.
- R8: While `bus_valid_o` is high and `bus_rdy_i` is low, the next cycle shows the same word, still valid (unless the token was withdrawn).
- R9: Samples and header are captured at the grant edge (idle, `tok_in_n` low, `data_rdy_i` high). Later changes to those inputs do not alter the words sent.
- R10: After reset, `bus_valid_o` is 0, `bus_data_o` is 0 and `tok_out_n` is 1.
- R11: If `tok_in_n` rises in the middle of a transfer, `bus_valid_o` drops in that same cycle. The transfer is abandoned and `tok_out_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_in_n | input | 1 | Incoming chain token, active low |
| master_i | input | 1 | Static master select; the master sends a header word |
| hdr_i | input | 32 | Status register value used as the header word |
| samples_i | input | NUM_CH*16 | Channel sample registers, channel c at bits 16c+15:16c |
| data_rdy_i | input | 1 | Samples are ready to be sent |
| bus_rdy_i | input | 1 | Bus sink accepts the current word |
| bus_data_o | output | 32 | Bus word; zero when not valid |
| bus_valid_o | output | 1 | Bus word valid |
| tok_out_n | output | 1 | Outgoing chain token, active low |

## Verification
The assertions assume the following about the inputs:
- `master_i` is static for the whole transfer.
- An upstream module releases the token only after seeing this module's `tok_out_n` low, or deliberately, as an abort.
- The sink may stall freely.

The bench keeps `master_i` fixed within each transfer and changes it only between transfers. It raises `tok_in_n` either after the handoff or at one planned point in the middle of a transfer. It drives `bus_rdy_i` with several fixed stall patterns and scrambles the samples and header right after each grant, so that the capture rule is actually exercised.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_HANDOFF = 2'd2
  } tcr_state_e;
endpackage

// File: rtl/tcr_seq.sv
module tcr_seq
  import tcr_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tok_in_n,
  input  logic                        master_i,
  input  logic                        data_rdy_i,
  input  logic                        bus_rdy_i,
  output logic                        valid_o,
  output logic                        grant_o,
  output logic                        hdr_sel_o,
  output logic [$clog2(NUM_CH/2)-1:0] pair_idx_o,
  output logic                        tok_out_n_o
);
  localparam int NPAIR  = NUM_CH / 2;
  localparam int CNT_W  = $clog2(NPAIR + 1);
  localparam int PAIR_W = $clog2(NPAIR);

  tcr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             master_q;
  logic [CNT_W-1:0] last_idx;
  logic             last_word;

  assign last_idx    = master_q ? CNT_W'(NPAIR) : CNT_W'(NPAIR - 1);
  assign last_word   = (cnt_q == last_idx);
  assign grant_o     = (state_q == ST_IDLE) && !tok_in_n && data_rdy_i;
  assign valid_o     = (state_q == ST_SEND) && !tok_in_n;
  assign hdr_sel_o   = master_q && (cnt_q == '0);
  assign pair_idx_o  = PAIR_W'(cnt_q - CNT_W'(master_q));
  assign tok_out_n_o = (state_q != ST_HANDOFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      master_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!tok_in_n) begin
            if (data_rdy_i) begin
              state_q  <= ST_SEND;
              cnt_q    <= '0;
              master_q <= master_i;
            end else begin
              state_q <= ST_HANDOFF;
            end
          end
        end
        ST_SEND: begin
          if (tok_in_n) begin
            state_q <= ST_IDLE;
          end else if (bus_rdy_i) begin
            if (last_word) state_q <= ST_HANDOFF;
            else           cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_HANDOFF: begin
          if (tok_in_n) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // word counter never runs past the transfer length
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND) |-> (cnt_q <= last_idx));

  // handoff and transfer never overlap
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && !tok_out_n_o));

  // outgoing token released after upstream token goes high
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_out_n_o && tok_in_n) |=> tok_out_n_o);

  // token passed straight on when data is not ready
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !tok_in_n && !data_rdy_i) |=> (!tok_out_n_o && !valid_o));
endmodule

// File: rtl/tcr_pack.sv
module tcr_pack #(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        capture_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  samples_i,
  input  logic [2*SAMPLE_W-1:0]       hdr_i,
  input  logic                        valid_i,
  input  logic                        hdr_sel_i,
  input  logic [$clog2(NUM_CH/2)-1:0] pair_idx_i,
  output logic [2*SAMPLE_W-1:0]       bus_data_o
);
  localparam int NPAIR = NUM_CH / 2;
  localparam int BUS_W = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] snap_q [NUM_CH];
  logic [BUS_W-1:0]    hdr_q;
  logic [BUS_W-1:0]    pair_w [NPAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hdr_q <= '0;
    else if (capture_i) hdr_q <= hdr_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         snap_q[c] <= '0;
      else if (capture_i) snap_q[c] <= samples_i[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_w[p] = {snap_q[2*p+1], snap_q[2*p]};
  end

  always_comb begin
    bus_data_o = '0;
    if (valid_i) bus_data_o = hdr_sel_i ? hdr_q : pair_w[pair_idx_i];
  end
endmodule

// File: rtl/tok_chain_readout.sv
module tok_chain_readout #(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tok_in_n,
  input  logic                       master_i,
  input  logic [2*SAMPLE_W-1:0]      hdr_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  input  logic                       data_rdy_i,
  input  logic                       bus_rdy_i,
  output logic [2*SAMPLE_W-1:0]      bus_data_o,
  output logic                       bus_valid_o,
  output logic                       tok_out_n
);
  localparam int PAIR_W = $clog2(NUM_CH / 2);

  logic              grant;
  logic              hdr_sel;
  logic [PAIR_W-1:0] pair_idx;

  tcr_seq #(.NUM_CH(NUM_CH)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_in_n    (tok_in_n),
    .master_i    (master_i),
    .data_rdy_i  (data_rdy_i),
    .bus_rdy_i   (bus_rdy_i),
    .valid_o     (bus_valid_o),
    .grant_o     (grant),
    .hdr_sel_o   (hdr_sel),
    .pair_idx_o  (pair_idx),
    .tok_out_n_o (tok_out_n)
  );

  tcr_pack #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) pack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (grant),
    .samples_i  (samples_i),
    .hdr_i      (hdr_i),
    .valid_i    (bus_valid_o),
    .hdr_sel_i  (hdr_sel),
    .pair_idx_i (pair_idx),
    .bus_data_o (bus_data_o)
  );

  p_valid_tok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> !tok_in_n);

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid_o |-> (bus_data_o == '0));

  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_rdy_i) |=> (tok_in_n || (bus_valid_o && $stable(bus_data_o))));
endmodule

// File: tb/tok_chain_readout_tb_top.sv
module tok_chain_readout_tb_top;
  localparam int NCH = 16;
  localparam int SW  = 16;
  localparam int NP  = NCH / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tok_in_n = 1'b1;
  logic              master_i = 1'b0;
  logic [2*SW-1:0]   hdr_i = '0;
  logic [NCH*SW-1:0] samples_i = '0;
  logic              data_rdy_i = 1'b0;
  logic              bus_rdy_i = 1'b0;
  logic [2*SW-1:0]   bus_data_o;
  logic              bus_valid_o;
  logic              tok_out_n;

  int errors = 0;
  int checks = 0;
  logic [SW-1:0]   smp [NCH];
  logic [2*SW-1:0] hdr_ref;

  always #10 clk = ~clk;

  tok_chain_readout #(.NUM_CH(NCH), .SAMPLE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_in_n(tok_in_n), .master_i(master_i),
    .hdr_i(hdr_i), .samples_i(samples_i), .data_rdy_i(data_rdy_i),
    .bus_rdy_i(bus_rdy_i), .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o),
    .tok_out_n(tok_out_n)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic rdy_pat(int s, int c);
    case (s)
      0:       return 1'b1;
      1:       return (c % 2) == 0;
      2:       return (c % 3) != 1;
      default: return ((c * 7) % 5) < 2;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(bit m, int idx);
    int k;
    if (m && idx == 0) return hdr_ref;
    k = m ? idx - 1 : idx;
    return {smp[2*k+1], smp[2*k]};
  endfunction

  task automatic load(input int tr);
    for (int c = 0; c < NCH; c++) begin
      smp[c] = 16'(tr * 16'h1357 + c * 16'h00F1) ^ 16'(c << 8);
      samples_i[c*SW +: SW] = smp[c];
    end
    hdr_ref = 32'hC0DE0000 | 32'(tr);
    hdr_i   = hdr_ref;
  endtask

  task automatic do_xfer(input bit m, input int s, input int tr);
    int idx = 0;
    int cyc = 0;
    int guard = 0;
    int nw = NP + (m ? 1 : 0);
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;
    logic r;
    load(tr);
    master_i = m;
    data_rdy_i = 1'b1;
    tok_in_n = 1'b0;
    bus_rdy_i = rdy_pat(s, 0);
    @(negedge clk);
    // R9: scramble inputs right after the grant edge
    samples_i = ~samples_i;
    hdr_i = ~hdr_i;
    while (idx < nw && guard < 300) begin
      check(32'(bus_valid_o), 32'd1, "R1 valid during transfer");
      check(bus_data_o, exp_word(m, idx), m ? "R2/R4/R9 word" : "R3/R4/R9 word");
      check(32'(tok_out_n), 32'd1, "R5 token held during transfer");
      if (prev_stall) check(bus_data_o, prev_data, "R8 word held under stall");
      r = rdy_pat(s, cyc);
      bus_rdy_i = r;
      if (r) idx++;
      prev_stall = !r;
      prev_data = bus_data_o;
      cyc++;
      guard++;
      @(negedge clk);
    end
    check(32'(tok_out_n), 32'd0, "R5 token out after last word");
    check(32'(bus_valid_o), 32'd0, "R3 no extra word");
    check(bus_data_o, 32'd0, "R7 bus zero after transfer");
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(32'(tok_out_n), 32'd0, "R5 token out holds");
    end
    tok_in_n = 1'b1;
    data_rdy_i = 1'b0;
    #1;
    check(32'(bus_valid_o), 32'd0, "R1 no valid without token");
    @(negedge clk);
    check(32'(tok_out_n), 32'd1, "R5 token out released");
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(32'(bus_valid_o), 32'd0, "R10 reset valid");
    check(bus_data_o, 32'd0, "R10 reset data");
    check(32'(tok_out_n), 32'd1, "R10 reset token");
    rst_n = 1'b1;
    @(negedge clk);

    for (int tr = 0; tr < 4; tr++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 4; s++)
          do_xfer(m[0], s, tr * 8 + m * 4 + s);

    // R6: token arrives before data is ready
    for (int m = 0; m < 2; m++) begin
      master_i = m[0];
      data_rdy_i = 1'b0;
      tok_in_n = 1'b0;
      @(negedge clk);
      check(32'(tok_out_n), 32'd0, "R6 immediate pass");
      check(32'(bus_valid_o), 32'd0, "R6 nothing sent");
      check(bus_data_o, 32'd0, "R7 bus zero on pass");
      tok_in_n = 1'b1;
      @(negedge clk);
      check(32'(tok_out_n), 32'd1, "R5 release after pass");
    end

    // R11: token withdrawn mid-transfer
    load(77);
    master_i = 1'b0;
    data_rdy_i = 1'b1;
    bus_rdy_i = 1'b1;
    tok_in_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_data_o, exp_word(1'b0, 2), "R11 third word before abort");
    tok_in_n = 1'b1;
    data_rdy_i = 1'b0;
    #1;
    check(32'(bus_valid_o), 32'd0, "R11 valid drops at once");
    check(bus_data_o, 32'd0, "R7 bus zero on abort");
    @(negedge clk);
    check(32'(tok_out_n), 32'd1, "R11 no token out on abort");
    check(32'(bus_valid_o), 32'd0, "R11 idle after abort");

    // fresh transfer after abort starts from the first word
    do_xfer(1'b1, 0, 99);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule